// File: doc/BRIEF.md
# Forward Calorimeter Trigger Primitive Builder

Each bunch crossing, this block receives 48 tower energies arranged as a 12 (pseudorapidity) by 4 (azimuth) grid. It reduces them to 8 trigger primitives. Each primitive covers a fixed patch of six towers: 3 along pseudorapidity by 2 along azimuth. For each patch the block forms a saturating energy sum. It also raises a shape flag when one tower holds more than a programmable share of that sum. A narrow, well-contained deposit can therefore be told apart from diffuse pileup.

The primitives are packed two to a word on four output lanes, ready for the serial links. A new set of inputs can be accepted on every clock, which is one crossing period. Results appear two clocks later together with a valid strobe. The share threshold is a 7-bit value in units of 1/128. It is captured together with the towers it applies to.

Top module: `tpg_builder`

## Requirements
- R1: Tower at azimuth row f (0..3) and pseudorapidity column e (0..11) occupies bits [(f*12+e)*8 +: 8] of `tower_e`. It contributes to primitive p = (f/2)*4 + e/3.
- R2: A primitive's energy is the sum of its six 8-bit towers, clipped to 1023 when the true sum exceeds 10 bits.
- R3: Lane l occupies bits [l*22 +: 22] of `lane_data`. The low 11 bits carry primitive 2l and the high 11 bits carry primitive 2l+1. Within each 11-bit field, bits 9:0 are the energy and bit 10 is the shape flag.
- R4: The shape flag is 1 when some tower of the patch satisfies tower*128 > share*E. E is the clipped energy of R2 and share is the 7-bit threshold captured with the towers. The arithmetic is exact integer arithmetic.
- R5: A primitive whose energy is zero always reports a flag of 0.
- R6: `out_valid` equals `in_valid` from two clocks earlier. `lane_data` shows the result of that input on the same cycle.
- R7: When `in_valid` is low, no state is updated. `lane_data` keeps the last valid result, and a threshold change without `in_valid` has no effect.
- R8: After reset, `out_valid` is 0 and `lane_data` is all zero until the first valid input reaches the output.
- R9: At threshold 0, every patch with nonzero energy is flagged. At threshold 127, a patch with a single nonzero tower is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crossing-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Tower set and threshold are valid this cycle |
| tower_e | input | 384 | 48 tower energies, 8 bits each |
| share_th | input | 7 | Dominance threshold in units of 1/128 |
| out_valid | output | 1 | Lane words hold a new primitive set |
| lane_data | output | 88 | Four lanes of two packed primitives |

## Verification
A wrong tower-to-patch mapping appears as two misplaced energy fields in the very next output word after any input that is not uniform. A missing clip appears only when a patch exceeds 1023, so saturated patches are driven on purpose. A threshold captured on the wrong cycle, or a stage enable stuck open, shows up as changed lane data during idle cycles or as wrong flags. These errors appear two clocks after the offending input. The reference model compares every field on every clock.

// File: rtl/tpg_pkg.sv
package tpg_pkg;
  // Default geometry and widths of the builder.
  localparam int unsigned DEF_TWR_W   = 8;
  localparam int unsigned DEF_SUM_W   = 10;
  localparam int unsigned DEF_FRAC_W  = 7;
  localparam int unsigned DEF_ETA_N   = 12;
  localparam int unsigned DEF_PHI_N   = 4;
  localparam int unsigned DEF_GRP_ETA = 3;
  localparam int unsigned DEF_GRP_PHI = 2;
  localparam int unsigned DEF_PER_LANE = 2;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/tpg_group_sum.sv
module tpg_group_sum #(
  parameter int unsigned TWR_W = 8,
  parameter int unsigned SUM_W = 10,
  parameter int unsigned GRP_N = 6,
  localparam int unsigned ACC_W = TWR_W + $clog2(GRP_N) + 1
) (
  input  logic [GRP_N*TWR_W-1:0] twr,
  output logic [SUM_W-1:0]       sum_sat,
  output logic [TWR_W-1:0]       twr_max
);
  localparam logic [ACC_W-1:0] SUM_MAX = ACC_W'((1 << SUM_W) - 1);

  logic [ACC_W-1:0] acc;

  always_comb begin
    acc     = '0;
    twr_max = '0;
    for (int k = 0; k < GRP_N; k++) begin
      acc = acc + ACC_W'(twr[k*TWR_W +: TWR_W]);
      if (twr[k*TWR_W +: TWR_W] > twr_max) twr_max = twr[k*TWR_W +: TWR_W];
    end
    sum_sat = (acc > SUM_MAX) ? SUM_MAX[SUM_W-1:0] : acc[SUM_W-1:0];
  end
endmodule

// File: rtl/tpg_flag_cmp.sv
module tpg_flag_cmp #(
  parameter int unsigned TWR_W  = 8,
  parameter int unsigned SUM_W  = 10,
  parameter int unsigned FRAC_W = 7,
  localparam int unsigned PROD_W = tpg_pkg::max_u(TWR_W, SUM_W) + FRAC_W
) (
  input  logic [SUM_W-1:0]  sum,
  input  logic [TWR_W-1:0]  twr_max,
  input  logic [FRAC_W-1:0] share,
  output logic              flag
);
  logic [PROD_W-1:0] lhs, rhs;

  always_comb begin
    lhs  = PROD_W'(twr_max) << FRAC_W;
    rhs  = PROD_W'(share) * PROD_W'(sum);
    flag = (sum != '0) && (lhs > rhs);
  end
endmodule

// File: rtl/tpg_builder.sv
module tpg_builder #(
  parameter int unsigned TWR_W    = tpg_pkg::DEF_TWR_W,
  parameter int unsigned SUM_W    = tpg_pkg::DEF_SUM_W,
  parameter int unsigned FRAC_W   = tpg_pkg::DEF_FRAC_W,
  parameter int unsigned ETA_N    = tpg_pkg::DEF_ETA_N,
  parameter int unsigned PHI_N    = tpg_pkg::DEF_PHI_N,
  parameter int unsigned GRP_ETA  = tpg_pkg::DEF_GRP_ETA,
  parameter int unsigned GRP_PHI  = tpg_pkg::DEF_GRP_PHI,
  parameter int unsigned PER_LANE = tpg_pkg::DEF_PER_LANE,
  localparam int unsigned N_TWR  = ETA_N * PHI_N,
  localparam int unsigned GE     = ETA_N / GRP_ETA,
  localparam int unsigned GP     = PHI_N / GRP_PHI,
  localparam int unsigned N_PRIM = GE * GP,
  localparam int unsigned GRP_N  = GRP_ETA * GRP_PHI,
  localparam int unsigned PRIM_W = SUM_W + 1,
  localparam int unsigned N_LANE = N_PRIM / PER_LANE,
  localparam int unsigned LANE_W = PRIM_W * PER_LANE
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [N_TWR*TWR_W-1:0]   tower_e,
  input  logic [FRAC_W-1:0]        share_th,
  output logic                     out_valid,
  output logic [N_LANE*LANE_W-1:0] lane_data
);
  // Stage 1 state and its next values
  logic                    s1_valid, s1_valid_nx;
  logic [SUM_W-1:0]        s1_sum    [N_PRIM];
  logic [SUM_W-1:0]        s1_sum_nx [N_PRIM];
  logic [TWR_W-1:0]        s1_max    [N_PRIM];
  logic [TWR_W-1:0]        s1_max_nx [N_PRIM];
  logic [FRAC_W-1:0]       s1_share, s1_share_nx;
  // Stage 2 next values
  logic                    out_valid_nx;
  logic [N_LANE*LANE_W-1:0] lane_nx;
  logic [N_PRIM-1:0]       flag_c;

  for (genvar p = 0; p < N_PRIM; p++) begin : g_prim
    localparam int unsigned EG = p % GE;
    localparam int unsigned PG = p / GE;
    logic [GRP_N*TWR_W-1:0] grp_twr;

    for (genvar k = 0; k < GRP_N; k++) begin : g_twr
      localparam int unsigned T = (PG*GRP_PHI + k/GRP_ETA)*ETA_N + EG*GRP_ETA + k%GRP_ETA;
      assign grp_twr[k*TWR_W +: TWR_W] = tower_e[T*TWR_W +: TWR_W];
    end

    tpg_group_sum #(.TWR_W(TWR_W), .SUM_W(SUM_W), .GRP_N(GRP_N)) u_sum (
      .twr     (grp_twr),
      .sum_sat (s1_sum_nx[p]),
      .twr_max (s1_max_nx[p])
    );

    tpg_flag_cmp #(.TWR_W(TWR_W), .SUM_W(SUM_W), .FRAC_W(FRAC_W)) u_cmp (
      .sum     (s1_sum[p]),
      .twr_max (s1_max[p]),
      .share   (s1_share),
      .flag    (flag_c[p])
    );
  end

  // Next-state logic
  always_comb begin
    s1_valid_nx  = in_valid;
    s1_share_nx  = share_th;
    out_valid_nx = s1_valid;
    for (int p = 0; p < N_PRIM; p++)
      lane_nx[p*PRIM_W +: PRIM_W] = {flag_c[p], s1_sum[p]};
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid  <= 1'b0;
      s1_share  <= '0;
      out_valid <= 1'b0;
      lane_data <= '0;
      for (int p = 0; p < N_PRIM; p++) begin
        s1_sum[p] <= '0;
        s1_max[p] <= '0;
      end
    end else begin
      s1_valid  <= s1_valid_nx;
      out_valid <= out_valid_nx;
      if (in_valid) begin
        s1_share <= s1_share_nx;
        for (int p = 0; p < N_PRIM; p++) begin
          s1_sum[p] <= s1_sum_nx[p];
          s1_max[p] <= s1_max_nx[p];
        end
      end
      if (s1_valid) lane_data <= lane_nx;
    end
  end
endmodule

// File: rtl/tpg_builder_chk.sv
module tpg_builder_chk #(
  parameter int unsigned SUM_W  = 10,
  parameter int unsigned N_PRIM = 8,
  localparam int unsigned PRIM_W = SUM_W + 1
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     in_valid,
  input logic                     s1_valid,
  input logic                     out_valid,
  input logic [N_PRIM*PRIM_W-1:0] lane_data
);
  logic [1:0] age;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  // R6
  out_valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2) |-> (out_valid == $past(in_valid, 2)));

  // R6
  stage_hand_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |=> out_valid);

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((age >= 2'd1) && !out_valid) |-> $stable(lane_data));

  for (genvar p = 0; p < N_PRIM; p++) begin : g_p
    // R5
    zero_noflag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lane_data[p*PRIM_W +: SUM_W] == '0) |-> !lane_data[p*PRIM_W + SUM_W]);
  end
endmodule

bind tpg_builder tpg_builder_chk #(.SUM_W(SUM_W), .N_PRIM(N_PRIM)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .s1_valid  (s1_valid),
  .out_valid (out_valid),
  .lane_data (lane_data)
);

// File: tb/tpg_builder_bench.sv
module tpg_builder_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [383:0] tower_e = '0;
  logic [6:0]  share_th = '0;
  logic        out_valid;
  logic [87:0] lane_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int twr [48];
  logic [88:0] exp_q [$];   // {valid, lane word}
  logic [87:0] last_word = '0;

  always #10 clk = ~clk;

  tpg_builder u_tpg_builder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .tower_e(tower_e),
    .share_th(share_th), .out_valid(out_valid), .lane_data(lane_data)
  );

  function automatic logic [87:0] model(input int sh);
    logic [87:0] w = '0;
    for (int p = 0; p < 8; p++) begin
      int s = 0;
      bit fl = 0;
      for (int f = 0; f < 4; f++)
        for (int e = 0; e < 12; e++)
          if ((f/2)*4 + e/3 == p) s += twr[f*12+e];
      if (s > 1023) s = 1023;
      for (int f = 0; f < 4; f++)
        for (int e = 0; e < 12; e++)
          if ((f/2)*4 + e/3 == p && twr[f*12+e]*128 > sh*s) fl = 1;
      if (s == 0) fl = 0;
      w[(p/2)*22 + (p%2)*11 +: 11] = {fl, 10'(s)};
    end
    return w;
  endfunction

  task automatic compare();
    logic [88:0] e = exp_q.pop_front();
    checks++;
    if (out_valid !== e[88]) begin
      errors++;
      $display("FAIL R6 out_valid actual %0b expected %0b", out_valid, e[88]);
    end
    for (int p = 0; p < 8; p++) begin
      int base = (p/2)*22 + (p%2)*11;
      checks += 2;
      if (lane_data[base +: 10] !== e[base +: 10]) begin
        errors++;
        $display("FAIL R2 prim %0d energy actual %0d expected %0d", p, lane_data[base +: 10], e[base +: 10]);
      end
      if (lane_data[base+10] !== e[base+10]) begin
        errors++;
        $display("FAIL R4 prim %0d flag actual %0b expected %0b", p, lane_data[base+10], e[base+10]);
      end
    end
  endtask

  // One cycle: check outputs, drive new inputs, predict their result.
  task automatic step(input bit v, input int sh);
    @(negedge clk);
    compare();
    for (int t = 0; t < 48; t++) tower_e[t*8 +: 8] = 8'(twr[t]);
    share_th = 7'(sh);
    in_valid = v;
    if (v) last_word = model(sh);
    exp_q.push_back({v, last_word});
  endtask

  task automatic fill(input int val);
    for (int t = 0; t < 48; t++) twr[t] = val;
  endtask

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog expired");
    done = 1;
  end

  initial begin
    fill(0);
    exp_q.push_back('0);
    exp_q.push_back('0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;            // R8: first compares see the reset state
    // R5: all-zero towers, any threshold
    step(1, 0);
    step(1, 127);
    // R9: single nonzero tower per patch, threshold 127 and 0
    fill(0);
    twr[0] = 5; twr[15] = 1; twr[30] = 200; twr[47] = 9;
    step(1, 127);
    step(1, 0);
    // R2 R4: saturated patches, threshold just below and at the boundary
    fill(255);
    step(1, 31);
    step(1, 32);
    // R7: idle cycles with a changed threshold must not alter the words
    fill(3);
    step(0, 5);
    step(0, 90);
    step(0, 1);
    // R1 R3: walk one tower through every position
    for (int t = 0; t < 48; t++) begin
      fill(1);
      twr[t] = 200;
      step(1, 64);
    end
    // Mixed random traffic with gaps
    for (int n = 0; n < 600; n++) begin
      for (int t = 0; t < 48; t++) twr[t] = ($urandom_range(0, 3) == 0) ? $urandom_range(0, 255) : $urandom_range(0, 20);
      step($urandom_range(0, 4) != 0, $urandom_range(0, 127));
    end
    fill(0);
    step(0, 0);
    step(0, 0);
    step(0, 0);
    done = 1;
  end

  initial begin
    wait (done);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule